// File: doc/BRIEF.md
# Latched Crosspoint Routing Datapath

This block is the data path of a 32-output crosspoint switch. Every output bit is routed from one of 64 source bits: a 32-bit primary bus and a 32-bit expansion bus, side by side. Each output has its own 6-bit select code. The 32 codes arrive together as one flat vector from configuration storage outside the block.

An input staging register sits in front of the routing network and an output staging register sits behind it. Both are loaded by strobes. The two strobes are sampled in the system clock domain, and a register loads on the clock edge where its strobe is seen going from high to low.

A registered mode flag chooses between two modes. In clocked mode the output bus shows the output staging register. In flow-through mode both staging registers are bypassed, so the output follows the live inputs through the live select codes without delay. The staging registers keep their contents, and go on loading on strobes, whatever the mode.

Top module: `xpt_switch`

## Requirements
- R1: While reset is asserted, both staging registers hold zero and, in clocked mode, the output bus reads zero.
- R2: Output bit o takes select code `sel_vec[6*o+5:6*o]`. Code c in 0..31 routes primary bit c, and code c in 32..63 routes expansion bit c-32.
- R3: On the clock edge where `in_strobe` is sampled low after being sampled high on the previous edge, the input stage loads `{exp_data, pri_data}`. It holds that value on every other edge.
- R4: On the clock edge where `out_strobe` is sampled low after being sampled high on the previous edge, the output stage loads the routing of the input stage's value through the current select vector.
- R5: In clocked mode, the output bus changes only on an output-strobe fall. Changes on the data buses, the select vector or the input strobe alone leave it unchanged.
- R6: `flow_mode` is registered on each clock edge (1 = flow-through, 0 = clocked). While the registered flag is 1, the output bus equals the live routing of the current inputs through the current select vector, within the same cycle.
- R7: When the registered flag returns to 0, the output bus again shows the output stage's held value.
- R8: When both strobes fall on the same edge, the output stage loads the routing of the input stage's previous contents, not the word that the input stage loads on that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| flow_mode | input | 1 | Mode request: 1 = flow-through, 0 = clocked |
| in_strobe | input | 1 | Input-stage load strobe; acts on its falling edge |
| out_strobe | input | 1 | Output-stage load strobe; acts on its falling edge |
| pri_data | input | 32 | Primary source bus (codes 0..31) |
| exp_data | input | 32 | Expansion source bus (codes 32..63) |
| sel_vec | input | 192 | 32 select codes of 6 bits each; code for output o at bits 6*o+5..6*o |
| dout | output | 32 | Routed output bus |

## Verification
Routing is first tried in flow-through mode with four select patterns. Identity selection against the primary bus and against the expansion bus separates the two halves of the code space. A bit-reversed selection exposes swapped or shifted indexing, and a broadcast of a single code to all outputs exposes outputs tied to their own index. In clocked mode, the data and select inputs are changed between strobe pulses to show which stage holds which word. Strobes pulsed one at a time and both together separate the input and output stages and check the order in which they load. Every cycle, the output is also compared with a behavioural model of both modes.

// File: rtl/xpt_pkg.sv
package xpt_pkg;

  localparam int unsigned XPT_OUTS  = 32;
  localparam int unsigned XPT_BUS_W = 32;

  typedef enum logic {
    XPT_CLOCKED = 1'b0,
    XPT_FLOW    = 1'b1
  } xpt_mode_e;

endpackage

// File: rtl/xpt_fall_det.sv
module xpt_fall_det (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl,
  output logic fall
);

  logic lvl_q;
  logic lvl_d;

  always_comb begin
    lvl_d = lvl;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q <= 1'b0;
    end else begin
      lvl_q <= lvl_d;
    end
  end

  assign fall = lvl_q & ~lvl;

endmodule

// File: rtl/xpt_stage.sv
module xpt_stage #(
  parameter int unsigned WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [WIDTH-1:0] q_r;
  logic [WIDTH-1:0] q_d;

  always_comb begin
    q_d = q_r;
    if (load) begin
      q_d = d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_r <= '0;
    end else begin
      q_r <= q_d;
    end
  end

  assign q = q_r;

endmodule

// File: rtl/xpt_route.sv
module xpt_route #(
  parameter int unsigned N_OUT = 32,
  parameter int unsigned N_SRC = 64,
  parameter int unsigned SEL_W = 6
) (
  input  logic [N_SRC-1:0]       src,
  input  logic [N_OUT*SEL_W-1:0] sel,
  output logic [N_OUT-1:0]       dst
);

  localparam int unsigned CODE_SPAN = 2 ** SEL_W;

  for (genvar o = 0; o < N_OUT; o++) begin : g_out
    logic [SEL_W-1:0] code;
    assign code = sel[o*SEL_W +: SEL_W];

    if (CODE_SPAN == N_SRC) begin : g_full
      assign dst[o] = src[code];
    end else begin : g_guard
      logic [CODE_SPAN-1:0] src_ext;
      assign src_ext = {{(CODE_SPAN-N_SRC){1'b0}}, src};
      assign dst[o]  = src_ext[code];
    end
  end

endmodule

// File: rtl/xpt_switch.sv
module xpt_switch #(
  parameter int unsigned N_OUT = xpt_pkg::XPT_OUTS,
  parameter int unsigned BUS_W = xpt_pkg::XPT_BUS_W
) (
  input  logic                                  clk,
  input  logic                                  rst_n,
  input  logic                                  flow_mode,
  input  logic                                  in_strobe,
  input  logic                                  out_strobe,
  input  logic [BUS_W-1:0]                      pri_data,
  input  logic [BUS_W-1:0]                      exp_data,
  input  logic [N_OUT*$clog2(2*BUS_W)-1:0]      sel_vec,
  output logic [N_OUT-1:0]                      dout
);

  import xpt_pkg::*;

  localparam int unsigned N_SRC = 2 * BUS_W;
  localparam int unsigned SEL_W = $clog2(N_SRC);

  // reset synchronizer: assert asynchronously, release on the clock
  logic rst_meta_q;
  logic rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  // mode flag
  xpt_mode_e mode_q;
  xpt_mode_e mode_d;

  always_comb begin
    mode_d = flow_mode ? XPT_FLOW : XPT_CLOCKED;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      mode_q <= XPT_CLOCKED;
    end else begin
      mode_q <= mode_d;
    end
  end

  // strobe edge detection
  logic in_fall;
  logic out_fall;

  xpt_fall_det u_in_fall (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .lvl   (in_strobe),
    .fall  (in_fall)
  );

  xpt_fall_det u_out_fall (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .lvl   (out_strobe),
    .fall  (out_fall)
  );

  // input stage
  logic [N_SRC-1:0] live_src;
  logic [N_SRC-1:0] in_q;

  assign live_src = {exp_data, pri_data};

  xpt_stage #(.WIDTH(N_SRC)) u_in_stage (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .load  (in_fall),
    .d     (live_src),
    .q     (in_q)
  );

  // routing networks: one from the held word, one from the live buses
  logic [N_OUT-1:0] route_stage;
  logic [N_OUT-1:0] route_live;

  xpt_route #(.N_OUT(N_OUT), .N_SRC(N_SRC), .SEL_W(SEL_W)) u_route_stage (
    .src (in_q),
    .sel (sel_vec),
    .dst (route_stage)
  );

  xpt_route #(.N_OUT(N_OUT), .N_SRC(N_SRC), .SEL_W(SEL_W)) u_route_live (
    .src (live_src),
    .sel (sel_vec),
    .dst (route_live)
  );

  // output stage
  logic [N_OUT-1:0] out_q;

  xpt_stage #(.WIDTH(N_OUT)) u_out_stage (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .load  (out_fall),
    .d     (route_stage),
    .q     (out_q)
  );

  // output select
  always_comb begin
    if (mode_q == XPT_FLOW) begin
      dout = route_live;
    end else begin
      dout = out_q;
    end
  end

endmodule

// File: rtl/xpt_switch_chk.sv
module xpt_switch_chk #(
  parameter int unsigned N_OUT = 32,
  parameter int unsigned N_SRC = 64
) (
  input logic             clk,
  input logic             rst_n,
  input logic             rst_sync_n,
  input logic             in_fall,
  input logic             out_fall,
  input logic             flow_q,
  input logic [N_SRC-1:0] live_src,
  input logic [N_SRC-1:0] in_q,
  input logic [N_OUT-1:0] route_stage,
  input logic [N_OUT-1:0] route_live,
  input logic [N_OUT-1:0] out_q,
  input logic [N_OUT-1:0] dout
);

  // R1
  always @(posedge clk) begin
    if (!rst_n) begin
      stages_clear_chk: assert (in_q == '0 && out_q == '0);
    end
  end

  // R3
  in_load_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    in_fall |=> in_q == $past(live_src));

  // R3
  in_hold_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !in_fall |=> $stable(in_q));

  // R4
  out_load_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    out_fall |=> out_q == $past(route_stage));

  // R5
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !out_fall |=> $stable(out_q));

  // R6
  flow_path_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    flow_q |-> dout == route_live);

  // R7
  clocked_path_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !flow_q |-> dout == out_q);

endmodule

bind xpt_switch xpt_switch_chk #(.N_OUT(N_OUT), .N_SRC(N_SRC)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .rst_sync_n  (rst_sync_n),
  .in_fall     (in_fall),
  .out_fall    (out_fall),
  .flow_q      (mode_q == xpt_pkg::XPT_FLOW),
  .live_src    (live_src),
  .in_q        (in_q),
  .route_stage (route_stage),
  .route_live  (route_live),
  .out_q       (out_q),
  .dout        (dout)
);

// File: tb/xpt_switch_tb.sv
module xpt_switch_tb;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         flow_mode;
  logic         in_strobe;
  logic         out_strobe;
  logic [31:0]  pri_data;
  logic [31:0]  exp_data;
  logic [191:0] sel_vec;
  logic [31:0]  dout;

  int n_checks = 0;
  int n_fail   = 0;
  bit run_live = 1'b0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  xpt_switch u_dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .flow_mode  (flow_mode),
    .in_strobe  (in_strobe),
    .out_strobe (out_strobe),
    .pri_data   (pri_data),
    .exp_data   (exp_data),
    .sel_vec    (sel_vec),
    .dout       (dout)
  );

  function automatic logic [31:0] route(input logic [63:0] src, input logic [191:0] sel);
    logic [31:0] r;
    for (int o = 0; o < 32; o++) begin
      int c;
      c = int'(sel[o*6 +: 6]);
      r[o] = (c < 32) ? src[c] : src[32 + (c - 32)];
    end
    return r;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: dout=%h expected=%h", req, act, exp);
    end
  endtask

  // behavioural reference model
  logic [63:0] m_in;
  logic [31:0] m_out;
  bit m_ip, m_op, m_flow;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_in = '0; m_out = '0; m_ip = 0; m_op = 0; m_flow = 0;
    end else begin
      if (m_op && !out_strobe) m_out = route(m_in, sel_vec);
      if (m_ip && !in_strobe)  m_in  = {exp_data, pri_data};
      m_ip = in_strobe;
      m_op = out_strobe;
      m_flow = flow_mode;
    end
  end

  always @(negedge clk) begin
    if (run_live) begin
      if (m_flow) check("R6 model", dout, route({exp_data, pri_data}, sel_vec));
      else        check("R5 model", dout, m_out);
    end
  end

  task automatic step(input int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1;
    end
  endtask

  task automatic sel_map(input int kind, input int code);
    for (int o = 0; o < 32; o++) begin
      case (kind)
        0: sel_vec[o*6 +: 6] = 6'(o);
        1: sel_vec[o*6 +: 6] = 6'(32 + o);
        2: sel_vec[o*6 +: 6] = 6'(31 - o);
        default: sel_vec[o*6 +: 6] = 6'(code);
      endcase
    end
  endtask

  task automatic pulse(input bit pi, input bit po);
    in_strobe = pi; out_strobe = po; step();
    in_strobe = 0;  out_strobe = 0;  step();
    step();
  endtask

  function automatic logic [31:0] bitrev(input logic [31:0] v);
    logic [31:0] r;
    for (int i = 0; i < 32; i++) r[i] = v[31 - i];
    return r;
  endfunction

  initial begin
    logic [31:0] held;
    logic [31:0] pa;
    logic [31:0] ea;
    rst_n = 0; flow_mode = 0; in_strobe = 0; out_strobe = 0;
    pri_data = 32'hDEAD_BEEF; exp_data = 32'hCAFE_F00D; sel_vec = '0;
    step(3);
    @(negedge clk);
    check("R1 reset", dout, 32'h0);
    @(posedge clk); #1;
    rst_n = 1;
    step(4);
    run_live = 1'b1;

    // R2 / R6 routing patterns in flow-through mode
    pri_data = 32'hA5C3_0F96; exp_data = 32'h9234_5678;
    flow_mode = 1; sel_map(0, 0); step();
    @(negedge clk); check("R2 identity primary", dout, 32'hA5C3_0F96);
    @(posedge clk); #1; sel_map(1, 0);
    @(negedge clk); check("R2 identity expansion", dout, 32'h9234_5678);
    @(posedge clk); #1; sel_map(2, 0);
    @(negedge clk); check("R2 reversed", dout, bitrev(32'hA5C3_0F96));
    @(posedge clk); #1; sel_map(3, 63);
    @(negedge clk); check("R2 broadcast code 63", dout, 32'hFFFF_FFFF);
    @(posedge clk); #1; sel_map(3, 1);
    @(negedge clk); check("R2 broadcast code 1", dout, 32'hFFFF_FFFF);
    @(posedge clk); #1; pri_data = 32'h0000_0001; sel_map(3, 1);
    @(negedge clk); check("R6 live data follows", dout, 32'h0);

    // R7 back to clocked: held zero
    @(posedge clk); #1; flow_mode = 0; step();
    @(negedge clk); check("R7 clocked shows held", dout, 32'h0);

    // R3: capture P1, change buses before output strobe
    @(posedge clk); #1;
    pa = 32'h1357_9BDF; ea = 32'h2468_ACE0;
    pri_data = pa; exp_data = ea; sel_map(0, 0);
    pulse(1, 0);
    pri_data = 32'h0F0F_0F0F; exp_data = 32'hF0F0_F0F0;
    pulse(0, 1);
    @(negedge clk); check("R3 input stage held word", dout, pa);

    // R4: output stage routes input stage through current select
    @(posedge clk); #1; sel_map(1, 0);
    pulse(0, 1);
    @(negedge clk); check("R4 expansion via stage", dout, ea);
    @(posedge clk); #1; sel_map(2, 0);
    pulse(0, 1);
    @(negedge clk); check("R4 reversed via stage", dout, bitrev(pa));
    held = bitrev(pa);

    // R5: no output strobe -> no change
    @(posedge clk); #1;
    sel_map(3, 5); pri_data = 32'hFFFF_FFFF; exp_data = 32'h0;
    pulse(1, 0);
    @(negedge clk); check("R5 hold after input strobe", dout, held);
    step(3);
    @(negedge clk); check("R5 hold idle", dout, held);

    // R8: both strobes fall together (input stage holds FFFFFFFF/0 now)
    @(posedge clk); #1;
    sel_map(0, 0); pri_data = 32'h3C3C_3C3C;
    pulse(1, 1);
    @(negedge clk); check("R8 simultaneous uses old word", dout, 32'hFFFF_FFFF);
    @(posedge clk); #1;
    pulse(0, 1);
    @(negedge clk); check("R8 next strobe uses new word", dout, 32'h3C3C_3C3C);
    held = 32'h3C3C_3C3C;

    // R7: flow excursion then return to held value
    @(posedge clk); #1; flow_mode = 1; pri_data = 32'h5555_AAAA; step();
    @(negedge clk); check("R6 flow excursion", dout, 32'h5555_AAAA);
    @(posedge clk); #1; flow_mode = 0; step();
    @(negedge clk); check("R7 return to held", dout, held);

    step(2);
    run_live = 1'b0;
    finished = 1'b1;
  end

  initial begin
    fork
      wait (finished);
      begin
        repeat (200000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog: run did not finish, expected completion");
      end
    join_any
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule